// File: doc/BRIEF.md
# Condition Register and Branch Resolver

This block keeps the eight 4-bit condition fields that compare operations produce, plus a loop count register and a return-address register. It also decides, in the same cycle that a branch is presented, whether that branch is taken and where it goes. A compare selects one destination field and writes a four-bit outcome there: less-than, greater-than, equal, and a summary-overflow bit copied from an external input. No other field changes.

A branch can do several things at once. It can count the loop register down and test the decremented value against zero with either sense. It can test any one of the 32 condition bits against 0 or 1. It is taken only when every enabled test passes. It can also record the address of the following instruction as a return address. The target comes from one of four sources: an absolute immediate, an immediate offset added to the current instruction address, the return-address register, or the count register. The two low bits of every target are cleared. The taken flag and the target are combinational outputs. The register updates land on the next rising clock edge.

Top module: `cr_branch_unit`

## Requirements
- R1: After reset, cr_q, ctr_q and lr_q are all zero. br_taken is 0 whenever br_valid is 0.
- R2: A compare (cmp_valid=1) writes only field f = cmp_field, which is cr_q[4f+3:4f], on the next rising edge. The other seven fields keep their values. Without a compare, cr_q does not change.
- R3: Within a field, bit 0 is LT, bit 1 is GT, bit 2 is EQ and bit 3 is SO. Flat condition bit i is cr_q[i], so bit 13 is field 3 GT. The comparison is signed when cmp_signed=1 and unsigned otherwise, and SO takes the value of so_in.
- R4: When br_valid and br_dec_ctr are both 1, the zero test uses ctr_q-1, and ctr_q becomes ctr_q-1 on the next edge whether or not the branch is taken (0 wraps to all ones). When br_dec_ctr=0, the count test passes and ctr_q is left unchanged.
- R5: br_taken = br_valid AND count-ok AND bit-ok. Count-ok is (ctr_q-1 == 0) when br_ctr_zero=1 and (ctr_q-1 != 0) when br_ctr_zero=0. Bit-ok is cr_q[br_bit_idx] == br_bit_sense when br_use_bit=1, and true otherwise.
- R6: br_tgt_sel picks the target: 0 gives br_imm, 1 gives br_cia+br_imm, 2 gives the current lr_q, 3 gives the current (not yet decremented) ctr_q.
- R7: When br_valid and br_link are both 1, lr_q becomes br_cia+4 on the next edge whether or not the branch is taken. A link-register target in the same operation uses the old lr_q.
- R8: The two low bits of br_target are always zero.
- R9: ctr_wr_en and lr_wr_en load ctr_wr_data and lr_wr_data on the next edge. In the same cycle, a branch decrement or a branch link to that register takes priority over the direct load.
- R10: A branch tests the condition bits as they were before any compare presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| cmp_signed | input | 1 | 1 = signed compare |
| cmp_field | input | 3 | Destination condition field |
| so_in | input | 1 | Summary overflow copied into SO |
| br_valid | input | 1 | Branch strobe |
| br_dec_ctr | input | 1 | Decrement and test the count register |
| br_ctr_zero | input | 1 | 1 = branch needs decremented count zero, 0 = nonzero |
| br_use_bit | input | 1 | Enable the condition-bit test |
| br_bit_sense | input | 1 | Required value of the tested bit |
| br_bit_idx | input | 5 | Flat index of the tested condition bit |
| br_tgt_sel | input | 2 | Target source: 0 abs, 1 rel, 2 link, 3 count |
| br_link | input | 1 | Save return address |
| br_cia | input | 32 | Address of the branch instruction |
| br_imm | input | 32 | Absolute address or signed offset |
| ctr_wr_en | input | 1 | Direct count register load |
| ctr_wr_data | input | 32 | Count register load value |
| lr_wr_en | input | 1 | Direct link register load |
| lr_wr_data | input | 32 | Link register load value |
| cr_q | output | 32 | Condition register |
| ctr_q | output | 32 | Count register |
| lr_q | output | 32 | Link register |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Branch target address |

## Verification
A compare that reaches the wrong field, or that corrupts a neighbouring field, shows up in cr_q one edge after the compare. It can also surface later as a wrong br_taken on a branch that tests a bit in that field. A count register that is off by one first shows as a wrong taken flag at loop exit, in the cycle the branch is presented. After the following edge it also shows as a wrong ctr_q. A return address that is wrong, or that is written at the wrong time, shows in lr_q one edge later, or as a wrong br_target on a branch that returns through it. The loop, link, same-cycle priority and wrap-around cases are run so that each of these faults reaches the ports.

// File: rtl/cr_pkg.sv
package cr_pkg;
  parameter int XLEN   = 32;
  parameter int NFIELD = 8;
  parameter int FW     = 4;
  localparam int CRW   = NFIELD * FW;
  localparam int FSELW = $clog2(NFIELD);
  localparam int BIDXW = $clog2(CRW);
  localparam int ALIGN = 2;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    TGT_ABS = 2'd0,
    TGT_REL = 2'd1,
    TGT_LNK = 2'd2,
    TGT_CNT = 2'd3
  } tgt_sel_e;

  // field layout: [0]=LT [1]=GT [2]=EQ [3]=SO
  function automatic logic [FW-1:0] cmp_nibble(input word_t a, input word_t b,
                                               input logic sgn, input logic so);
    logic lt, gt, eq;
    eq = (a == b);
    if (sgn) begin
      lt = ($signed(a) < $signed(b));
      gt = ($signed(a) > $signed(b));
    end else begin
      lt = (a < b);
      gt = (a > b);
    end
    cmp_nibble = {so, eq, gt, lt};
  endfunction

  function automatic word_t pick_target(input tgt_sel_e sel, input word_t cia,
                                        input word_t imm, input word_t lr,
                                        input word_t ctr);
    word_t raw;
    case (sel)
      TGT_ABS: raw = imm;
      TGT_REL: raw = cia + imm;
      TGT_LNK: raw = lr;
      default: raw = ctr;
    endcase
    pick_target = {raw[XLEN-1:ALIGN], {ALIGN{1'b0}}};
  endfunction

  function automatic word_t return_addr(input word_t cia);
    return_addr = cia + word_t'(4);
  endfunction
endpackage

// File: rtl/cr_field_file.sv
module cr_field_file
  import cr_pkg::*;
#(
  parameter int N = NFIELD,
  parameter int W = FW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [$clog2(N)-1:0]   wr_sel,
  input  logic [W-1:0]           wr_nib,
  output logic [N*W-1:0]         cr_q,
  output logic [N-1:0]           fld_wr
);
  for (genvar f = 0; f < N; f++) begin : g_fld
    assign fld_wr[f] = wr_en && (wr_sel == f[$clog2(N)-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cr_q[f*W +: W] <= '0;
      else if (fld_wr[f])
        cr_q[f*W +: W] <= wr_nib;
    end
  end
endmodule

// File: rtl/cr_branch_cond.sv
module cr_branch_cond
  import cr_pkg::*;
(
  input  logic             br_valid,
  input  logic             br_dec_ctr,
  input  logic             br_ctr_zero,
  input  logic             br_use_bit,
  input  logic             br_bit_sense,
  input  logic [BIDXW-1:0] br_bit_idx,
  input  logic [1:0]       br_tgt_sel,
  input  word_t            br_cia,
  input  word_t            br_imm,
  input  logic [CRW-1:0]   cr_q,
  input  word_t            ctr_q,
  input  word_t            lr_q,
  output word_t            ctr_dec,
  output logic             ctr_ok,
  output logic             bit_ok,
  output logic             br_taken,
  output word_t            br_target
);
  logic ctr_is_zero;

  always_comb begin
    ctr_dec     = ctr_q - word_t'(1);
    ctr_is_zero = (ctr_dec == '0);
    ctr_ok      = !br_dec_ctr || (ctr_is_zero == br_ctr_zero);
    bit_ok      = !br_use_bit || (cr_q[br_bit_idx] == br_bit_sense);
    br_taken    = br_valid && ctr_ok && bit_ok;
    br_target   = pick_target(tgt_sel_e'(br_tgt_sel), br_cia, br_imm, lr_q, ctr_q);
  end
endmodule

// File: rtl/cr_spr_regs.sv
module cr_spr_regs
  import cr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctr_br_upd,
  input  word_t ctr_br_val,
  input  logic  ctr_wr_en,
  input  word_t ctr_wr_data,
  input  logic  lr_br_upd,
  input  word_t lr_br_val,
  input  logic  lr_wr_en,
  input  word_t lr_wr_data,
  output word_t ctr_q,
  output word_t lr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
      lr_q  <= '0;
    end else begin
      if (ctr_br_upd)     ctr_q <= ctr_br_val;
      else if (ctr_wr_en) ctr_q <= ctr_wr_data;
      if (lr_br_upd)      lr_q  <= lr_br_val;
      else if (lr_wr_en)  lr_q  <= lr_wr_data;
    end
  end
endmodule

// File: rtl/cr_branch_unit.sv
module cr_branch_unit
  import cr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic [XLEN-1:0]  cmp_a,
  input  logic [XLEN-1:0]  cmp_b,
  input  logic             cmp_signed,
  input  logic [FSELW-1:0] cmp_field,
  input  logic             so_in,
  input  logic             br_valid,
  input  logic             br_dec_ctr,
  input  logic             br_ctr_zero,
  input  logic             br_use_bit,
  input  logic             br_bit_sense,
  input  logic [BIDXW-1:0] br_bit_idx,
  input  logic [1:0]       br_tgt_sel,
  input  logic             br_link,
  input  logic [XLEN-1:0]  br_cia,
  input  logic [XLEN-1:0]  br_imm,
  input  logic             ctr_wr_en,
  input  logic [XLEN-1:0]  ctr_wr_data,
  input  logic             lr_wr_en,
  input  logic [XLEN-1:0]  lr_wr_data,
  output logic [CRW-1:0]   cr_q,
  output logic [XLEN-1:0]  ctr_q,
  output logic [XLEN-1:0]  lr_q,
  output logic             br_taken,
  output logic [XLEN-1:0]  br_target
);
  // named internal events, observed by the checker
  logic [FW-1:0]     cmp_nib;
  logic [NFIELD-1:0] fld_wr;
  word_t             ctr_dec;
  logic              ctr_ok;
  logic              bit_ok;
  logic              ctr_br_upd;
  logic              lr_br_upd;
  word_t             ret_addr;

  assign cmp_nib    = cmp_nibble(cmp_a, cmp_b, cmp_signed, so_in);
  assign ctr_br_upd = br_valid && br_dec_ctr;
  assign lr_br_upd  = br_valid && br_link;
  assign ret_addr   = return_addr(br_cia);

  cr_field_file #(.N(NFIELD), .W(FW)) u_cr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cmp_valid),
    .wr_sel (cmp_field),
    .wr_nib (cmp_nib),
    .cr_q   (cr_q),
    .fld_wr (fld_wr)
  );

  cr_branch_cond u_cond (
    .br_valid     (br_valid),
    .br_dec_ctr   (br_dec_ctr),
    .br_ctr_zero  (br_ctr_zero),
    .br_use_bit   (br_use_bit),
    .br_bit_sense (br_bit_sense),
    .br_bit_idx   (br_bit_idx),
    .br_tgt_sel   (br_tgt_sel),
    .br_cia       (br_cia),
    .br_imm       (br_imm),
    .cr_q         (cr_q),
    .ctr_q        (ctr_q),
    .lr_q         (lr_q),
    .ctr_dec      (ctr_dec),
    .ctr_ok       (ctr_ok),
    .bit_ok       (bit_ok),
    .br_taken     (br_taken),
    .br_target    (br_target)
  );

  cr_spr_regs u_spr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctr_br_upd  (ctr_br_upd),
    .ctr_br_val  (ctr_dec),
    .ctr_wr_en   (ctr_wr_en),
    .ctr_wr_data (ctr_wr_data),
    .lr_br_upd   (lr_br_upd),
    .lr_br_val   (ret_addr),
    .lr_wr_en    (lr_wr_en),
    .lr_wr_data  (lr_wr_data),
    .ctr_q       (ctr_q),
    .lr_q        (lr_q)
  );
endmodule

// File: rtl/cr_branch_chk.sv
module cr_branch_chk
  import cr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_valid,
  input logic [XLEN-1:0]  cmp_a,
  input logic [XLEN-1:0]  cmp_b,
  input logic [FSELW-1:0] cmp_field,
  input logic             br_valid,
  input logic             br_dec_ctr,
  input logic             br_use_bit,
  input logic             br_bit_sense,
  input logic [BIDXW-1:0] br_bit_idx,
  input logic             br_link,
  input logic [XLEN-1:0]  br_cia,
  input logic [CRW-1:0]   cr_q,
  input logic [XLEN-1:0]  ctr_q,
  input logic [XLEN-1:0]  lr_q,
  input logic             br_taken,
  input logic [XLEN-1:0]  br_target
);
  logic [FSELW-1:0] fld_d;
  logic [CRW-1:0]   keep_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_d <= '0;
    else        fld_d <= cmp_field;
  end
  assign keep_mask = ~({{(CRW-FW){1'b0}}, {FW{1'b1}}} << (fld_d * FW));

  a_r2_other_fields_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> (((cr_q ^ $past(cr_q)) & keep_mask) == '0));

  a_r2_no_cmp_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(cr_q));

  a_r3_equal_sets_eq: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_a == cmp_b) |=> cr_q[fld_d*FW + 2]);

  a_r4_ctr_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_dec_ctr) |=> (ctr_q == $past(ctr_q) - 1));

  a_r5_bit_test_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && br_use_bit) |-> (cr_q[br_bit_idx] == br_bit_sense));

  a_r1_no_valid_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> !br_taken);

  a_r7_link_written: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_link) |=> (lr_q == $past(br_cia) + 4));

  always_comb begin
    if (rst_n) a_r8_aligned: assert (br_target[1:0] == 2'b00);
  end
endmodule

bind cr_branch_unit cr_branch_chk u_chk (.*);

// File: tb/sim_cr_branch_unit.sv
module sim_cr_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid, cmp_signed, so_in;
  logic [31:0] cmp_a, cmp_b;
  logic [2:0]  cmp_field;
  logic        br_valid, br_dec_ctr, br_ctr_zero, br_use_bit, br_bit_sense, br_link;
  logic [4:0]  br_bit_idx;
  logic [1:0]  br_tgt_sel;
  logic [31:0] br_cia, br_imm;
  logic        ctr_wr_en, lr_wr_en;
  logic [31:0] ctr_wr_data, lr_wr_data;
  logic [31:0] cr_q, ctr_q, lr_q, br_target;
  logic        br_taken;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] cr_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  cr_branch_unit u0 (.*);

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        sgn;
    logic [2:0]  fld;
    logic        so;
    logic [3:0]  nib;  // {SO,EQ,GT,LT}
  } cvec_t;

  localparam int NV = 8;
  localparam cvec_t CV [NV] = '{
    '{32'd20,         32'd20,         1'b0, 3'd3, 1'b0, 4'b0100},
    '{32'd22,         32'd23,         1'b0, 3'd4, 1'b0, 4'b0001},
    '{32'd23,         32'd22,         1'b0, 3'd0, 1'b1, 4'b1010},
    '{32'hFFFF_FFFF,  32'd1,          1'b1, 3'd7, 1'b0, 4'b0001},
    '{32'hFFFF_FFFF,  32'd1,          1'b0, 3'd7, 1'b0, 4'b0010},
    '{32'd5,          32'd5,          1'b0, 3'd1, 1'b1, 4'b1100},
    '{32'd0,          32'h8000_0000,  1'b1, 3'd2, 1'b0, 4'b0010},
    '{32'd7,          32'd9,          1'b0, 3'd6, 1'b0, 4'b0001}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    cmp_valid = 0; cmp_a = 0; cmp_b = 0; cmp_signed = 0; cmp_field = 0; so_in = 0;
    br_valid = 0; br_dec_ctr = 0; br_ctr_zero = 0; br_use_bit = 0; br_bit_sense = 0;
    br_bit_idx = 0; br_tgt_sel = 0; br_link = 0; br_cia = 0; br_imm = 0;
    ctr_wr_en = 0; ctr_wr_data = 0; lr_wr_en = 0; lr_wr_data = 0;
  endtask

  task automatic load(input logic [31:0] c, input logic [31:0] l);
    @(negedge clk);
    ctr_wr_en = 1; ctr_wr_data = c; lr_wr_en = 1; lr_wr_data = l;
    @(negedge clk);
    idle();
  endtask

  // drive one branch at a negedge, sample combinational results 1 time unit later,
  // then release at the next negedge (after the registering edge)
  task automatic branch(input logic dec, input logic zs, input logic ub, input logic bs,
                        input logic [4:0] idx, input logic [1:0] sel, input logic lk,
                        input logic [31:0] cia, input logic [31:0] imm,
                        output logic tk, output logic [31:0] tg);
    @(negedge clk);
    br_valid = 1; br_dec_ctr = dec; br_ctr_zero = zs; br_use_bit = ub;
    br_bit_sense = bs; br_bit_idx = idx; br_tgt_sel = sel; br_link = lk;
    br_cia = cia; br_imm = imm;
    #1;
    tk = br_taken; tg = br_target;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic tk;
    logic [31:0] tg;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cr_q after reset", cr_q, 32'h0);
    chk("R1 ctr_q after reset", ctr_q, 32'h0);
    chk("R1 lr_q after reset", lr_q, 32'h0);
    br_use_bit = 1; br_bit_sense = 0; #1;
    chk("R1 no take without valid", {31'h0, br_taken}, 32'h0);
    idle();

    // R2 R3 compare vector table
    cr_m = 32'h0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmp_valid = 1; cmp_a = CV[i].a; cmp_b = CV[i].b; cmp_signed = CV[i].sgn;
      cmp_field = CV[i].fld; so_in = CV[i].so;
      @(negedge clk);
      idle();
      cr_m[CV[i].fld*4 +: 4] = CV[i].nib;
      chk($sformatf("R2 R3 compare vector %0d", i), cr_q, cr_m);
    end
    @(negedge clk);
    chk("R2 idle keeps cr", cr_q, cr_m);

    // R4 R5 R6 counted loop: ctr 3, branch while decremented count nonzero, relative target
    load(32'd3, 32'h2000);
    branch(1, 0, 0, 0, 5'd0, 2'd1, 0, 32'h100, 32'hFFFF_FFF0, tk, tg);
    chk("R5 loop pass 1 taken", {31'h0, tk}, 32'h1);
    chk("R6 relative target", tg, 32'h0000_00F0);
    chk("R4 ctr after pass 1", ctr_q, 32'd2);
    branch(1, 0, 0, 0, 5'd0, 2'd1, 0, 32'h100, 32'hFFFF_FFF0, tk, tg);
    chk("R5 loop pass 2 taken", {31'h0, tk}, 32'h1);
    branch(1, 0, 0, 0, 5'd0, 2'd1, 0, 32'h100, 32'hFFFF_FFF0, tk, tg);
    chk("R4 loop exit not taken", {31'h0, tk}, 32'h0);
    chk("R4 ctr at exit", ctr_q, 32'd0);

    // R3 R5 R7 bit 13 = field 3 GT (0), branch if false, link target with link
    load(32'd5, 32'h2000);
    branch(1, 0, 1, 0, 5'd13, 2'd2, 1, 32'h400, 32'h0, tk, tg);
    chk("R5 bit13 false taken", {31'h0, tk}, 32'h1);
    chk("R7 target is old lr", tg, 32'h2000);
    chk("R7 lr after link", lr_q, 32'h404);
    chk("R4 ctr after dec", ctr_q, 32'd4);
    branch(1, 0, 1, 1, 5'd13, 2'd2, 1, 32'h500, 32'h0, tk, tg);
    chk("R5 bit13 true not taken", {31'h0, tk}, 32'h0);
    chk("R7 link on not taken", lr_q, 32'h504);
    chk("R4 dec on not taken", ctr_q, 32'd3);

    // R8 absolute target unaligned, unconditional, ctr untouched
    branch(0, 0, 0, 0, 5'd0, 2'd0, 0, 32'h0, 32'h1237, tk, tg);
    chk("R5 unconditional taken", {31'h0, tk}, 32'h1);
    chk("R8 absolute aligned", tg, 32'h1234);
    chk("R4 no dec keeps ctr", ctr_q, 32'd3);

    // R6 R8 count register target, pre-decrement value
    load(32'h3003, 32'h2000);
    branch(1, 1, 0, 0, 5'd0, 2'd3, 0, 32'h0, 32'h0, tk, tg);
    chk("R6 ctr target old value", tg, 32'h3000);
    chk("R5 zero sense nonzero fails", {31'h0, tk}, 32'h0);

    // R5 zero sense with count reaching zero, then wrap
    load(32'd1, 32'h2000);
    branch(1, 1, 0, 0, 5'd0, 2'd0, 0, 32'h0, 32'h40, tk, tg);
    chk("R5 count hits zero taken", {31'h0, tk}, 32'h1);
    branch(1, 0, 0, 0, 5'd0, 2'd0, 0, 32'h0, 32'h40, tk, tg);
    chk("R5 wrapped count nonzero taken", {31'h0, tk}, 32'h1);
    chk("R4 ctr wraps", ctr_q, 32'hFFFF_FFFF);

    // R9 priority of branch update over direct load
    @(negedge clk);
    br_valid = 1; br_dec_ctr = 1; br_link = 1; br_cia = 32'h800;
    ctr_wr_en = 1; ctr_wr_data = 32'h77; lr_wr_en = 1; lr_wr_data = 32'h99;
    @(negedge clk);
    idle();
    chk("R9 branch dec beats load", ctr_q, 32'hFFFF_FFFE);
    chk("R9 branch link beats load", lr_q, 32'h804);
    load(32'h77, 32'h99);
    chk("R9 direct ctr load", ctr_q, 32'h77);
    chk("R9 direct lr load", lr_q, 32'h99);

    // R10 compare into field 3 and branch on bit 14 (field 3 EQ, currently 1) together
    @(negedge clk);
    cmp_valid = 1; cmp_a = 32'd22; cmp_b = 32'd23; cmp_field = 3'd3;
    br_valid = 1; br_use_bit = 1; br_bit_sense = 1; br_bit_idx = 5'd14;
    #1;
    tk = br_taken;
    @(negedge clk);
    idle();
    chk("R10 branch sees old cr", {31'h0, tk}, 32'h1);
    cr_m[15:12] = 4'b0001;
    chk("R10 compare landed", cr_q, cr_m);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule